// File: doc/BRIEF.md
# Lane-Partitioned Leading Sign Bit Counter

This block takes a 128-bit operand and a 32-bit instruction word. It splits the operand into signed lanes of 8, 16 or 32 bits, all the same width for a given operation. For each lane it counts how many bits directly below the lane's top bit match that top bit, scanning downward and stopping at the first bit that differs. The top bit itself is not counted.

The instruction word chooses the lane width and whether the operation covers the lower 64 bits or all 128 bits. It also carries fixed opcode bits, and the block checks them. Each accepted operation gives a registered result one cycle later. Every count sits zero-extended in the same lane position as its operand.

The block has no flag outputs. A bad encoding is reported on a separate output, and the result for it is zero.

Top module: `lane_sign_count`

## Requirements
- R1: The lane width comes from instr[19:18]: 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Every lane of one operation has the same width.
- R2: Each lane's result is the number of consecutive bits, starting just below the lane's top bit and moving down, that equal the top bit. The count stops at the first bit that differs.
- R3: A lane that is all zeros or all ones returns the lane width minus one (7, 15 or 31).
- R4: Each count is written into the same lane position and lane width as its operand, zero-extended inside the lane.
- R5: instr[6] = 0 selects a 64-bit operation. Result bits 127:64 are zero, and operand bits 127:64 have no effect. instr[6] = 1 processes all 128 bits.
- R6: When instr[19:18] = 2'b11, out_illegal is 1 and the result is all zeros.
- R7: When instr[11:7] is not 5'b01000, or instr[17:16] is not 2'b00, out_illegal is 1 and the result is all zeros.
- R8: When in_valid is high at a rising edge, result, out_illegal and out_valid are updated at that edge. When in_valid is low, out_valid is 0 and result keeps its last value.
- R9: rst_n is a synchronous, active-low reset. It clears out_valid, out_illegal and result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| instr | input | 32 | Instruction word: lane size, length bit, fixed opcode bits |
| operand | input | 128 | Source vector |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 128 | Per-lane leading sign bit counts |
| out_illegal | output | 1 | The registered operation had a bad encoding |

## Verification
Two things can affect the same operation. One is the lane-width choice that steers the shared counting tree. The other is the 64-bit length masking, which cuts lanes off at the half-vector boundary. Every lane width is therefore run with both length settings. In 64-bit mode the upper operand half is filled with non-zero data, and the whole 128-bit result is compared against a bit-by-bit reference. Operations go in back to back with the lane width changing between them, so that any state left from the previous width would show up in the next result.

// File: rtl/lsc_pkg.sv
// Package: shared lane-size encoding and fixed opcode values for the
// leading sign bit counter. Assumes the size field is two bits wide.
package lsc_pkg;
    typedef enum logic [1:0] {
        LANE_8   = 2'b00,
        LANE_16  = 2'b01,
        LANE_32  = 2'b10,
        LANE_BAD = 2'b11
    } lane_sz_e;

    localparam logic [4:0] OPC_MID = 5'b01000;   // instr[11:7]
    localparam logic [1:0] OPC_LOW = 2'b00;      // instr[17:16]
endpackage

// File: rtl/lsc_decode.sv
// Module: instruction-word decoder. It extracts the lane size and the
// length bit, and flags any encoding that is not a valid count operation.
// Assumes the instruction word is stable while in_valid is high.
module lsc_decode
    import lsc_pkg::*;
(
    input  logic [31:0] instr,
    output lane_sz_e    lane_sz,
    output logic        wide,
    output logic        bad_enc
);
    // Pick the fields out and test the fixed bits.
    always_comb begin
        lane_sz = lane_sz_e'(instr[19:18]);
        wide    = instr[6];
        bad_enc = (instr[19:18] == LANE_BAD) ||
                  (instr[11:7] != OPC_MID)   ||
                  (instr[17:16] != OPC_LOW);
    end
endmodule

// File: rtl/lsc_lzc_leaf.sv
// Module: leading-zero counter for one narrow slice.
// Output range is 0..W; W means the slice is all zeros.
module lsc_lzc_leaf #(
    parameter int W  = 8,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] cnt
);
    // Find the highest set bit by scanning downward.
    always_comb begin
        logic found;
        found = 1'b0;
        cnt   = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && x[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsc_lzc_merge.sv
// Module: joins the leading-zero counts of two adjacent half slices of
// width HW into the count for the full slice. Assumes each input count
// is in 0..HW.
module lsc_lzc_merge #(
    parameter int HW  = 8,
    localparam int ICW = $clog2(HW) + 1,
    localparam int OCW = $clog2(2 * HW) + 1
) (
    input  logic [ICW-1:0] hi,
    input  logic [ICW-1:0] lo,
    output logic [OCW-1:0] cnt
);
    // If the upper half is all zeros, add the lower half's count.
    always_comb begin
        if (hi == ICW'(HW))
            cnt = OCW'(HW) + OCW'(lo);
        else
            cnt = OCW'(hi);
    end
endmodule

// File: rtl/lane_sign_count.sv
// Module: top level of the lane-partitioned leading sign bit counter.
// It XORs each bit with its lane's sign, counts leading zeros in 8-bit
// leaves, and merges the leaves into 16- and 32-bit counts, so one tree
// serves every lane width. The result has one register stage.
// Assumes VEC_W is a multiple of 64.
module lane_sign_count
    import lsc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] operand,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             out_illegal
);
    localparam int HALF_W = VEC_W / 2;
    localparam int NB     = VEC_W / 8;
    localparam int NH     = VEC_W / 16;
    localparam int NW     = VEC_W / 32;

    lane_sz_e         lane_sz;
    logic             wide;
    logic             bad_enc;
    logic [VEC_W-1:0] op_m;
    logic [VEC_W-1:0] sgn;
    logic [VEC_W-1:0] diff;
    logic [3:0]       c8  [NB];
    logic [4:0]       c16 [NH];
    logic [5:0]       c32 [NW];
    logic [VEC_W-1:0] lanes;
    logic [VEC_W-1:0] next_res;

    lsc_decode u_dec (
        .instr   (instr),
        .lane_sz (lane_sz),
        .wide    (wide),
        .bad_enc (bad_enc)
    );

    // Clear the upper operand half for 64-bit operations.
    always_comb op_m = wide ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};

    // Copy each lane's sign bit across the lane and mark the bits that differ from it.
    for (genvar i = 0; i < VEC_W; i++) begin : g_sgn
        assign sgn[i] = (lane_sz == LANE_32) ? op_m[(i / 32) * 32 + 31] :
                        (lane_sz == LANE_16) ? op_m[(i / 16) * 16 + 15] :
                                               op_m[(i / 8) * 8 + 7];
    end
    assign diff = op_m ^ sgn;

    for (genvar b = 0; b < NB; b++) begin : g_leaf
        lsc_lzc_leaf #(.W(8)) u_leaf (.x(diff[b*8 +: 8]), .cnt(c8[b]));
    end
    for (genvar h = 0; h < NH; h++) begin : g_m16
        lsc_lzc_merge #(.HW(8)) u_m (.hi(c8[2*h+1]), .lo(c8[2*h]), .cnt(c16[h]));
    end
    for (genvar w = 0; w < NW; w++) begin : g_m32
        lsc_lzc_merge #(.HW(16)) u_m (.hi(c16[2*w+1]), .lo(c16[2*w]), .cnt(c32[w]));
    end

    // Place each count minus one (the sign bit's own zero) into its lane.
    always_comb begin
        lanes = '0;
        case (lane_sz)
            LANE_16: for (int h = 0; h < NH; h++) lanes[h*16 +: 16] = 16'(c16[h]) - 16'd1;
            LANE_32: for (int w = 0; w < NW; w++) lanes[w*32 +: 32] = 32'(c32[w]) - 32'd1;
            default: for (int b = 0; b < NB; b++) lanes[b*8 +: 8]   = 8'(c8[b]) - 8'd1;
        endcase
    end

    // Zero the unused upper half and any bad encoding.
    always_comb begin
        next_res = lanes;
        if (!wide) next_res[VEC_W-1:HALF_W] = '0;
        if (bad_enc) next_res = '0;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            result      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= next_res;
                out_illegal <= bad_enc;
            end
        end
    end
endmodule

// File: rtl/lsc_checker.sv
// Module: property checker for lane_sign_count, attached with bind.
// It only observes the top module's ports.
module lsc_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic [VEC_W-1:0] operand,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             out_illegal
);
    localparam int HALF_W = VEC_W / 2;

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[6]) |=> (result[VEC_W-1:HALF_W] == '0));
    p_size_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[19:18] == 2'b11) |=> (out_illegal && result == '0));
    p_opcode_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[11:7] != 5'b01000) |=> out_illegal);
    p_byte_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[19:18] == 2'b00) |=> ((result & {(VEC_W/8){8'hF8}}) == '0));
    p_half_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[19:18] == 2'b01) |=> ((result & {(VEC_W/16){16'hFFF0}}) == '0));
    p_word_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[19:18] == 2'b10) |=> ((result & {(VEC_W/32){32'hFFFF_FFE0}}) == '0));
endmodule

bind lane_sign_count lsc_checker #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .operand     (operand),
    .out_valid   (out_valid),
    .result      (result),
    .out_illegal (out_illegal)
);

// File: tb/sim_lane_sign_count.sv
// Scoreboard bench: the driver pushes reference results into a queue,
// and the monitor pops and compares them at each valid output.
module sim_lane_sign_count;
    typedef struct {
        logic [127:0] res;
        logic         ill;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] operand = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         out_illegal;

    int           checks = 0;
    int           errors = 0;
    int           cycles = 0;
    exp_t         sb[$];
    logic [127:0] last_res = '0;
    logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    lane_sign_count u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .operand(operand), .out_valid(out_valid), .result(result),
        .out_illegal(out_illegal)
    );

    // Build a legal instruction word from a size code and the length bit.
    function automatic logic [31:0] mk_ins(int sz, bit wide);
        mk_ins = 32'hF3B0_0400 | (32'(sz) << 18) | (32'(wide) << 6);
    endfunction

    // Bit-by-bit reference model written from the requirements.
    function automatic exp_t ref_model(logic [31:0] ins, logic [127:0] op);
        exp_t e;
        int   w, n, cnt;
        logic s;
        bit   stop;
        e.res = '0;
        e.ill = (ins[19:18] == 2'b11) || (ins[11:7] != 5'b01000) || (ins[17:16] != 2'b00);
        if (e.ill) return e;
        w = 8 << ins[19:18];
        n = (ins[6] ? 128 : 64) / w;
        for (int l = 0; l < n; l++) begin
            s = op[l*w + w - 1];
            cnt = 0;
            stop = 0;
            for (int j = w - 2; j >= 0; j--) begin
                if (!stop && op[l*w + j] == s) cnt++;
                else stop = 1;
            end
            for (int k = 0; k < w; k++) e.res[l*w + k] = (k < 32) ? cnt[k] : 1'b0;
        end
        return e;
    endfunction

    function automatic logic [127:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return {rng, ~rng ^ {rng[31:0], rng[63:32]}};
    endfunction

    task automatic drive(logic [31:0] ins, logic [127:0] op, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        instr    = ins;
        operand  = op;
        e = ref_model(ins, op);
        e.tag = tag;
        sb.push_back(e);
        last_res = e.res;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare whenever a result is valid.
    always @(negedge clk) begin
        if (out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected out_valid", 128'(out_valid), 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res && out_illegal == e.ill, e.tag,
                      {result[126:0], out_illegal}, {e.res[126:0], e.ill});
                if (result != e.res) $display("     (upper bit view) actual=%h expected=%h", result, e.res);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state.
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_illegal == 0 && result == '0, "R9 reset clear",
              {result[126:0], out_valid}, 128'd0);
        rst_n = 1'b1;

        for (int sz = 0; sz < 3; sz++) begin
            for (int wd = 0; wd < 2; wd++) begin
                logic [31:0] ins;
                ins = mk_ins(sz, wd[0]);
                drive(ins, '0, "R3 all zeros");
                drive(ins, '1, "R3 all ones");
                drive(ins, {16{8'hAA}}, "R2 alternating AA");
                drive(ins, {16{8'h55}}, "R2 alternating 55");
                for (int p = 0; p < 128; p++) begin
                    drive(ins, 128'd1 << p, "R2 single one");
                    drive(ins, ~(128'd1 << p), "R2 single zero");
                end
                for (int r = 0; r < 40; r++) drive(ins, next_rand(), "R4 mixed lanes");
                // R5: upper half filled with data that must not matter in 64-bit mode.
                drive(ins, {64'hDEAD_BEEF_0123_4567, 64'h0000_00FF_F000_0001}, "R5 upper ignored");
                // R1: change the lane width on the very next operation.
                drive(mk_ins((sz + 1) % 3, wd[0]), {8{16'h00F0}}, "R1 width switch");
            end
        end

        drive(32'hF3BC_0440, next_rand(), "R6 size 11");
        drive(32'hF3BC_0400, '1, "R6 size 11 narrow");
        drive(32'hF3B0_0C40, next_rand(), "R7 bad mid opcode");
        drive(32'hF3B1_0440, next_rand(), "R7 bad low opcode");
        drive(32'hF3B4_0480, {8{16'h0F0F}}, "R7 bad mid bit7");
        drive(mk_ins(2, 1), {4{32'h0000_7FFF}}, "R4 after illegal");

        // R8: the result holds while idle.
        idle(3);
        check(out_valid == 0 && result == last_res, "R8 hold when idle", result, last_res);

        // R9: a reset that arrives after an operation clears the outputs.
        drive(mk_ins(0, 1), {16{8'h03}}, "R4 before reset");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_illegal == 0 && result == '0, "R9 reset mid run",
              result, 128'd0);
        rst_n = 1'b1;
        idle(2);
        check(sb.size() == 0, "R8 scoreboard drained", 128'(sb.size()), 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule